// File: doc/BRIEF.md
# Three-Channel Compare Timer

This block holds three independent 16-bit up-counters behind a small memory-mapped register port. A single free-running prescaler, clocked by the master clock, produces one-cycle tick enables at six fixed division ratios. Each channel picks one of them through its mode register. A running channel in compare mode advances once per selected tick. The new counter value is compared against three compare registers, A, B and C. A match sets a sticky flag in the channel's status register. An optional setting returns the counter to zero when it matches C.

Software starts and stops a channel through a write-only control address. It reads the accumulated flags from a status address, and that read clears them. It builds an interrupt mask by writing to separate set and clear addresses. Each channel drives its own level interrupt, which is high while any flagged event is also unmasked. Each channel is controlled by a two-state machine:
- `CH_IDLE`: the counter holds its value.
- `CH_RUN`: the counter advances on ticks.

The transitions are:
- START: a control write whose low two bits are `01` moves `CH_IDLE` or `CH_RUN` to `CH_RUN` and clears the counter.
- STOP: a control write with bit 1 set moves `CH_RUN` to `CH_IDLE`.

Top module: `tmr_block`

## Requirements
- R1: After reset the following are zero: every mode, counter, compare, status and mask register, the read data and all interrupts. Every channel is in `CH_IDLE`.
- R2: Address bits [7:6] select the channel window: 0, 1 or 2. Window 3 reads as zero and ignores writes. Bits [5:0] select the register:
  - control at 0x00
  - mode at 0x04
  - counter at 0x10
  - compare A at 0x14, compare B at 0x18, compare C at 0x1C
  - status at 0x20
  - mask-set at 0x24, mask-clear at 0x28
  - mask read-back at 0x2C

  Control, mask-set, mask-clear and any other offset read as zero. Read data appears on the clock edge that samples the read strobe and holds until the next read.
- R3: Mode and the three compare registers store the 16 written bits and read them back unchanged. The counter is read-only.
- R4: Mode bits [2:0] pick the tick rate: 0 gives /2, 1 gives /8, 2 gives /32, 3 gives /128 and 4 gives /1024. The values 5 to 7 give /16. The shared prescaler is a 10-bit counter that starts at 0 when reset ends. A /N tick occurs in every cycle where that counter modulo N equals N-1.
- R5: A control write with bits [1:0] = `01` clears the counter and enters `CH_RUN`, even if the channel is already running. A control write with bit 1 set enters `CH_IDLE`. A control write with bits [1:0] = `00` has no effect.
- R6: The counter adds one on a selected tick only in `CH_RUN` and only with mode bit 15 (compare mode) set. In `CH_IDLE`, or with bit 15 clear, it holds. A tick in the cycle of a start write is not counted.
- R7: Without a C reset, the counter wraps from 0xFFFF to 0.
- R8: After an increment, the new value is compared with each compare register. A match with A sets status bit 2, a match with B sets bit 3 and a match with C sets bit 4.
- R9: With mode bit 14 set, a match with C loads zero into the counter instead of the matching value, and still sets status bit 4.
- R10: A status read returns the flags held before the read and clears them. Flags stay set until a status read. A match in the same cycle as the read is kept.
- R11: A write to mask-set ORs data bits [4:0] into the mask. A write to mask-clear clears the mask bits where the data has ones. The mask reads back at 0x2C.
- R12: Each channel's interrupt is high exactly while (status AND mask) is nonzero. The three channels are independent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 8 | Byte address: window in [7:6], offset in [5:0] |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 3 | Level interrupt, one bit per channel |

## Verification
- A read result is due one clock edge after the edge that samples the strobe.
- A write takes effect on the edge that samples it.
- An interrupt follows the status and mask registers within the same cycle, since it is combinational from them.
- The counter responds to a tick on the edge of the cycle in which the prescaler's low bits are all ones.

The bench drives every access on a falling edge. A cycle-accurate arithmetic model advances on each rising edge, using the same strobes and a prescaler phase counted from reset. The bench compares the port values at the following falling edge, so each result is read exactly one register stage after its cause. Reads issued back to back against fast-running channels make status reads coincide with fresh matches.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W  = 16;
    localparam int FLG_W  = 5;
    localparam int OFF_W  = 6;
    localparam int NUM_DV = 6;

    localparam logic [OFF_W-1:0] OFF_CTRL = 6'h00;
    localparam logic [OFF_W-1:0] OFF_MODE = 6'h04;
    localparam logic [OFF_W-1:0] OFF_CNT  = 6'h10;
    localparam logic [OFF_W-1:0] OFF_CMPA = 6'h14;
    localparam logic [OFF_W-1:0] OFF_CMPB = 6'h18;
    localparam logic [OFF_W-1:0] OFF_CMPC = 6'h1C;
    localparam logic [OFF_W-1:0] OFF_STAT = 6'h20;
    localparam logic [OFF_W-1:0] OFF_MSET = 6'h24;
    localparam logic [OFF_W-1:0] OFF_MCLR = 6'h28;
    localparam logic [OFF_W-1:0] OFF_MASK = 6'h2C;

    localparam int MODE_CMP  = 15;
    localparam int MODE_CRST = 14;
    localparam int FLG_A = 2;
    localparam int FLG_B = 3;
    localparam int FLG_C = 4;

    typedef enum logic [0:0] {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    // log2 of the divider behind each tick line; index 5 is the fallback
    function automatic int div_exp(int idx);
        case (idx)
            0: return 1;
            1: return 3;
            2: return 5;
            3: return 7;
            4: return 10;
            default: return 4;
        endcase
    endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int PW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [NUM_DV-1:0] tick_o
);
    logic [PW-1:0] pcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) pcnt <= '0;
        else        pcnt <= pcnt + 1'b1;
    end

    for (genvar g = 0; g < NUM_DV; g++) begin : g_tick
        localparam int E = div_exp(g);
        assign tick_o[g] = &pcnt[E-1:0];
    end

    // R4
    div2_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o[0] |=> !tick_o[0]);
    // R4
    slow_nests_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o[4] |-> (&tick_o));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_DV-1:0] tick_i,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]  rdata_o,
    output logic              irq_o
);
    ch_state_e        state, state_nx;
    logic [CNT_W-1:0] mode, cmp_a, cmp_b, cmp_c, cnt;
    logic [FLG_W-1:0] flg, msk, hits;
    logic             start_cmd, stop_cmd, stat_rd, tick, count_en;
    logic [CNT_W-1:0] cnt_inc;
    logic [2:0]       div_idx;

    assign start_cmd = wr_en && off_i == OFF_CTRL && wdata_i[1:0] == 2'b01;
    assign stop_cmd  = wr_en && off_i == OFF_CTRL && wdata_i[1];
    assign stat_rd   = rd_en && off_i == OFF_STAT;
    assign div_idx   = (mode[2:0] <= 3'd4) ? mode[2:0] : 3'd5;
    assign tick      = tick_i[div_idx];
    assign count_en  = state == CH_RUN && mode[MODE_CMP] && tick && !start_cmd;
    assign cnt_inc   = cnt + 1'b1;

    always_comb begin
        hits        = '0;
        hits[FLG_A] = count_en && cnt_inc == cmp_a;
        hits[FLG_B] = count_en && cnt_inc == cmp_b;
        hits[FLG_C] = count_en && cnt_inc == cmp_c;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE: if (start_cmd) state_nx = CH_RUN;
            CH_RUN:  if (stop_cmd)  state_nx = CH_IDLE;
                     else if (start_cmd) state_nx = CH_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start_cmd) begin
            cnt <= '0;
        end else if (count_en) begin
            cnt <= (hits[FLG_C] && mode[MODE_CRST]) ? '0 : cnt_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= '0;
            cmp_a <= '0;
            cmp_b <= '0;
            cmp_c <= '0;
            msk   <= '0;
            flg   <= '0;
        end else begin
            flg <= (stat_rd ? '0 : flg) | hits;
            if (wr_en) begin
                unique case (off_i)
                    OFF_MODE: mode  <= wdata_i;
                    OFF_CMPA: cmp_a <= wdata_i;
                    OFF_CMPB: cmp_b <= wdata_i;
                    OFF_CMPC: cmp_c <= wdata_i;
                    OFF_MSET: msk   <= msk | wdata_i[FLG_W-1:0];
                    OFF_MCLR: msk   <= msk & ~wdata_i[FLG_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        irq_o = |(flg & msk);
        unique case (off_i)
            OFF_MODE: rdata_o = mode;
            OFF_CNT:  rdata_o = cnt;
            OFF_CMPA: rdata_o = cmp_a;
            OFF_CMPB: rdata_o = cmp_b;
            OFF_CMPC: rdata_o = cmp_c;
            OFF_STAT: rdata_o = {{(CNT_W-FLG_W){1'b0}}, flg};
            OFF_MASK: rdata_o = {{(CNT_W-FLG_W){1'b0}}, msk};
            default:  rdata_o = '0;
        endcase
    end

    // R5
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_cmd |=> (cnt == '0 && state == CH_RUN));
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_IDLE && !start_cmd) |=> $stable(cnt));
    // R7
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && cnt == '1) |=> cnt == '0);
    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((flg & $past(flg)) == $past(flg)));
    // R10
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && hits == '0) |=> (flg == '0 && !irq_o));
endmodule

// File: rtl/tmr_block.sv
module tmr_block
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NUM_CH = 3,
    parameter int PW     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int SEL_W = ADDR_W - OFF_W;

    logic [NUM_DV-1:0] ticks;
    logic [SEL_W-1:0]  win;
    logic [OFF_W-1:0]  off;
    logic [CNT_W-1:0]  ch_rd [NUM_CH];
    logic [CNT_W-1:0]  rd_mux;

    assign win = bus_addr[ADDR_W-1:OFF_W];
    assign off = bus_addr[OFF_W-1:0];

    tmr_prescale #(.PW(PW)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (ticks)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit_win;
        assign hit_win = int'(win) == c;
        tmr_chan u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (ticks),
            .wr_en   (bus_wr && hit_win),
            .rd_en   (bus_rd && hit_win),
            .off_i   (off),
            .wdata_i (bus_wdata),
            .rdata_o (ch_rd[c]),
            .irq_o   (irq[c])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (int'(win) == c) rd_mux = ch_rd[c];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    // R2
    empty_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && int'(win) >= NUM_CH) |=> bus_rdata == '0);
    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/tmr_block_bench.sv
`timescale 1ns/1ps
module tmr_block_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    tmr_block u_tmr_block (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // arithmetic model of the requirements
    int          m_pre;
    logic [15:0] m_mode [3];
    logic [15:0] m_a [3];
    logic [15:0] m_b [3];
    logic [15:0] m_c [3];
    logic [15:0] m_cnt [3];
    logic [4:0]  m_flg [3];
    logic [4:0]  m_msk [3];
    bit          m_run [3];
    logic [15:0] m_exp;

    function automatic int div_of(logic [2:0] s);
        case (s)
            3'd0: return 2;
            3'd1: return 8;
            3'd2: return 32;
            3'd3: return 128;
            3'd4: return 1024;
            default: return 16;
        endcase
    endfunction

    function automatic logic [15:0] model_read(logic [7:0] a);
        int ch = int'(a[7:6]);
        if (ch > 2) return 16'h0;
        case (a[5:0])
            6'h04: return m_mode[ch];
            6'h10: return m_cnt[ch];
            6'h14: return m_a[ch];
            6'h18: return m_b[ch];
            6'h1C: return m_c[ch];
            6'h20: return {11'h0, m_flg[ch]};
            6'h2C: return {11'h0, m_msk[ch]};
            default: return 16'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0;
            m_exp = '0;
            for (int c = 0; c < 3; c++) begin
                m_mode[c] = '0; m_a[c] = '0; m_b[c] = '0; m_c[c] = '0;
                m_cnt[c] = '0; m_flg[c] = '0; m_msk[c] = '0; m_run[c] = 1'b0;
            end
        end else begin
            if (bus_rd) m_exp = model_read(bus_addr);
            for (int c = 0; c < 3; c++) begin
                automatic int dv = div_of(m_mode[c][2:0]);
                automatic bit tk = (m_pre % dv) == dv - 1;
                automatic bit sel = int'(bus_addr[7:6]) == c;
                automatic bit wr = bus_wr && sel;
                automatic bit st_rd = bus_rd && sel && bus_addr[5:0] == 6'h20;
                automatic bit start = wr && bus_addr[5:0] == 6'h00 && bus_wdata[1:0] == 2'b01;
                automatic bit stop = wr && bus_addr[5:0] == 6'h00 && bus_wdata[1];
                automatic logic [4:0] hits = '0;
                automatic logic [15:0] nv;
                if (start) begin
                    m_cnt[c] = '0;
                end else if (m_run[c] && m_mode[c][15] && tk) begin
                    nv = m_cnt[c] + 16'd1;
                    if (nv == m_a[c]) hits[2] = 1'b1;
                    if (nv == m_b[c]) hits[3] = 1'b1;
                    if (nv == m_c[c]) hits[4] = 1'b1;
                    m_cnt[c] = (hits[4] && m_mode[c][14]) ? 16'd0 : nv;
                end
                if (start) m_run[c] = 1'b1;
                else if (stop) m_run[c] = 1'b0;
                m_flg[c] = (st_rd ? 5'd0 : m_flg[c]) | hits;
                if (wr) begin
                    case (bus_addr[5:0])
                        6'h04: m_mode[c] = bus_wdata;
                        6'h14: m_a[c] = bus_wdata;
                        6'h18: m_b[c] = bus_wdata;
                        6'h1C: m_c[c] = bus_wdata;
                        6'h24: m_msk[c] = m_msk[c] | bus_wdata[4:0];
                        6'h28: m_msk[c] = m_msk[c] & ~bus_wdata[4:0];
                        default: ;
                    endcase
                end
            end
            m_pre = (m_pre + 1) % 1024;
        end
    end

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(logic [7:0] a, string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        check(tag, bus_rdata, m_exp);
    endtask

    task automatic irq_chk(string tag);
        logic [2:0] e;
        for (int c = 0; c < 3; c++) e[c] = |(m_flg[c] & m_msk[c]);
        check(tag, {13'h0, irq}, {13'h0, e});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 rdata", bus_rdata, 16'h0);
        check("R1 irq", {13'h0, irq}, 16'h0);
        rd_chk(8'h04, "R1 mode");
        rd_chk(8'h10, "R1 counter");
        rd_chk(8'h1C, "R1 cmpC");
        rd_chk(8'h20, "R1 status");
        rd_chk(8'hAC, "R1 mask ch2");
        check("R1 explicit zero", bus_rdata, 16'h0);

        // R7 setup: channel 1 at /2, all compares zero, runs to wrap
        wr(8'h44, 16'h8000);
        wr(8'h40, 16'h0001);

        // R3 / R2 register readback and map
        wr(8'h14, 16'h1234);
        wr(8'h18, 16'hBEEF);
        wr(8'h1C, 16'h0F0F);
        wr(8'h94, 16'h00A5);
        rd_chk(8'h14, "R3 cmpA ch0");
        rd_chk(8'h18, "R3 cmpB ch0");
        rd_chk(8'h1C, "R3 cmpC ch0");
        rd_chk(8'h94, "R3 cmpA ch2");
        rd_chk(8'h54, "R2 cmpA ch1 separate");
        wr(8'hD4, 16'hFFFF);
        rd_chk(8'hD4, "R2 window 3 reads zero");
        rd_chk(8'h3C, "R2 unmapped offset");
        rd_chk(8'h24, "R2 mask-set reads zero");
        rd_chk(8'h00, "R2 control reads zero");

        // R4 sweep of all divider selects, R5/R6 stop hold
        for (int s = 0; s < 8; s++) begin
            wr(8'h04, 16'h8000 | 16'(s));
            rd_chk(8'h04, "R3 mode readback");
            wr(8'h00, 16'h0001);
            repeat (1100) @(negedge clk);
            rd_chk(8'h10, "R4 tick rate");
            wr(8'h00, 16'h0002);
            repeat (40) @(negedge clk);
            rd_chk(8'h10, "R5 stop hold");
            rd_chk(8'h10, "R6 idle ignores ticks");
        end
        wr(8'h00, 16'h0000);
        rd_chk(8'h10, "R5 control 00 no effect");
        rd_chk(8'h20, "R10 status ch0");

        // R6 compare mode off: no counting
        wr(8'h04, 16'h0000);
        wr(8'h00, 16'h0001);
        repeat (60) @(negedge clk);
        rd_chk(8'h10, "R6 compare mode off");
        check("R6 counter zero", bus_rdata, 16'h0);

        // R7 wait for channel 1 to pass the wrap
        repeat (131000) @(negedge clk);
        rd_chk(8'h50, "R7 wrapped counter");
        rd_chk(8'h60, "R8 flags at wrap");
        rd_chk(8'h60, "R10 cleared after read");

        // R8 / R11 / R12 on channel 2
        wr(8'h94, 16'd3);
        wr(8'h98, 16'd5);
        wr(8'h9C, 16'd7);
        wr(8'h84, 16'h8000);
        wr(8'hA4, 16'h0008);
        rd_chk(8'hAC, "R11 mask set");
        wr(8'h80, 16'h0001);
        repeat (20) @(negedge clk);
        irq_chk("R12 irq on B");
        rd_chk(8'hA0, "R8 flags A B C");
        irq_chk("R12 irq after read");
        wr(8'hA4, 16'h0004);
        rd_chk(8'hAC, "R11 mask or");
        wr(8'hA8, 16'h0008);
        rd_chk(8'hAC, "R11 mask clear");

        // R9 / R10 C reset with back-to-back reads
        wr(8'hA4, 16'h0010);
        wr(8'h84, 16'hC000);
        wr(8'h80, 16'h0001);
        for (int i = 0; i < 40; i++) begin
            rd_chk(8'h90, "R9 counter bounded by C");
            rd_chk(8'hA0, "R10 read vs new match");
            irq_chk("R12 per channel");
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                repeat (195000) @(posedge clk);
                if (!done) begin
                    errors++;
                    vectors++;
                    $display("FAIL watchdog: actual hung expected done");
                end
            end
            wait (done);
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule